// File: doc/BRIEF.md
# Cluster Integer ALU with Min/Max and Carry Word

This block is the integer arithmetic and logic unit of one execution cluster. It takes two operand words and an operation code, and it returns a result word one clock edge later. It covers addition, subtraction, six bitwise boolean functions, and both signed and unsigned minimum and maximum. Every one of these takes a single cycle. Multiply, divide and shifts are handled by a separate auxiliary unit, and register storage is outside the block.

The block has no carry flag. Add-with-carry is the second half of a fused operation pair. It takes its incoming carry from bit 0 of a third operand word. It returns the outgoing carry as a full data word, either 1 or 0, which the cluster writes to a secondary destination register. Because the carry is an ordinary register value, a multi-word addition chains through the register file.

Top module: `cl_alu`

## Requirements
- R1: While `rst_n` is low, `res_o` and `cw_o` are held at zero.
- R2: Outputs are registered. Operands and code sampled at one rising edge appear on `res_o`/`cw_o` after that edge and stay until the next edge.
- R3: Code 0 (add) yields `a + b` modulo 2^W. Code 1 (subtract) yields `a - b` modulo 2^W.
- R4: Code 2 (add-with-carry) yields `a + b + c[0]` modulo 2^W. `cw_o` is 1 when that sum exceeds 2^W-1 and 0 otherwise. Bits W-1..1 of `c` have no effect.
- R5: For every code other than 2, `cw_o` is zero, including when an add or subtract wraps.
- R6: Codes 3..8 give the bitwise functions AND, OR, XOR, `a & ~b`, `a | ~b` and XNOR, in that order.
- R7: Code 9 gives the unsigned minimum and code 10 the unsigned maximum of `a` and `b`.
- R8: Code 11 gives the signed minimum and code 12 the signed maximum, with both operands read as two's complement. When the operands are equal, the result is operand `a`.
- R9: Unassigned codes 13..15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| opc_i | input | WIDTH | Third operand; bit 0 is the carry-in |
| res_o | output | WIDTH | Registered result |
| cw_o | output | WIDTH | Registered carry word (1 or 0) |

## Verification
The bench builds the block with its default WIDTH of 32, so each expected value is a hand-computed 32-bit constant. At that width the all-ones wrap of add-with-carry can be reached, along with the carry generated from two set sign bits. The boundary between the most negative and most positive values can also be reached, which separates the signed from the unsigned comparisons. Noise in the upper bits of the carry-in word shows that only bit 0 is used.

// File: rtl/cl_alu_pkg.sv
package cl_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADC  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_ANDN = 4'd6,
        OP_ORN  = 4'd7,
        OP_XNOR = 4'd8,
        OP_UMIN = 4'd9,
        OP_UMAX = 4'd10,
        OP_SMIN = 4'd11,
        OP_SMAX = 4'd12
    } alu_op_e;

endpackage

// File: rtl/cl_alu_addsub.sv
module cl_alu_addsub
    import cl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               cin,
    output logic [WIDTH-1:0]   sum,
    output logic               cout
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [EXT_W-1:0] full;

    always_comb begin
        b_eff = b;
        c_eff = 1'b0;
        if (op == OP_SUB) begin
            b_eff = ~b;
            c_eff = 1'b1;
        end else if (op == OP_ADC) begin
            c_eff = cin;
        end
        full = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
        sum  = full[WIDTH-1:0];
        cout = full[WIDTH];
    end
endmodule

// File: rtl/cl_alu_logic.sv
module cl_alu_logic
    import cl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/cl_alu_minmax.sv
module cl_alu_minmax
    import cl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);
    logic is_signed;
    logic b_below;
    logic a_below;

    always_comb begin
        is_signed = (op == OP_SMIN) || (op == OP_SMAX);
        if (is_signed) begin
            b_below = $signed(b) < $signed(a);
            a_below = $signed(a) < $signed(b);
        end else begin
            b_below = b < a;
            a_below = a < b;
        end
        unique case (op)
            OP_UMIN, OP_SMIN: y = b_below ? b : a;
            OP_UMAX, OP_SMAX: y = a_below ? b : a;
            default:          y = '0;
        endcase
    end
endmodule

// File: rtl/cl_alu.sv
module cl_alu
    import cl_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [WIDTH-1:0]  opa_i,
    input  logic [WIDTH-1:0]  opb_i,
    input  logic [WIDTH-1:0]  opc_i,
    output logic [WIDTH-1:0]  res_o,
    output logic [WIDTH-1:0]  cw_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic [WIDTH-1:0] cw;
    } out_t;

    alu_op_e          op;
    logic [WIDTH-1:0] arith_y;
    logic             arith_c;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] mm_y;
    logic             unused_chi;
    out_t             out_d;
    out_t             out_q;

    assign op         = alu_op_e'(op_i);
    assign unused_chi = ^opc_i[WIDTH-1:1];

    cl_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op   (op),
        .a    (opa_i),
        .b    (opb_i),
        .cin  (opc_i[0]),
        .sum  (arith_y),
        .cout (arith_c)
    );

    cl_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op (op),
        .a  (opa_i),
        .b  (opb_i),
        .y  (logic_y)
    );

    cl_alu_minmax #(.WIDTH(WIDTH)) u_minmax (
        .op (op),
        .a  (opa_i),
        .b  (opb_i),
        .y  (mm_y)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD, OP_SUB: out_d.res = arith_y;
            OP_ADC: begin
                out_d.res = arith_y;
                out_d.cw  = {{(WIDTH-1){1'b0}}, arith_c};
            end
            OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_XNOR:
                out_d.res = logic_y;
            OP_UMIN, OP_UMAX, OP_SMIN, OP_SMAX:
                out_d.res = mm_y;
            default: out_d = '0;
        endcase
        if (!rst_n) out_d = '0;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign res_o = out_q.res;
    assign cw_o  = out_q.cw;
endmodule

// File: rtl/cl_alu_chk.sv
module cl_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [WIDTH-1:0]  opa_i,
    input logic [WIDTH-1:0]  opb_i,
    input logic [WIDTH-1:0]  opc_i,
    input logic [WIDTH-1:0]  res_o,
    input logic [WIDTH-1:0]  cw_o
);
    logic unused_c;
    assign unused_c = ^opc_i;

    logic [WIDTH-1:0] wide_sum;
    assign wide_sum = opa_i + opb_i;

    // R1: reset drives outputs to zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && cw_o == '0));

    // R3: add result after one edge
    a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0) |=> (res_o == $past(wide_sum)));

    // R4: carry word only ever 0 or 1
    a_r4_cw_bit: assert property (@(posedge clk) disable iff (!rst_n)
        cw_o[WIDTH-1:1] == '0);

    // R5: no carry word outside add-with-carry
    a_r5_cw_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd2) |=> (cw_o == '0));

    // R7: unsigned minimum never exceeds either operand
    a_r7_umin_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |=> (res_o <= $past(opa_i) && res_o <= $past(opb_i)));

    // R8: signed maximum not below either operand
    a_r8_smax_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd12) |=> ($signed(res_o) >= $signed($past(opa_i)) &&
                             $signed(res_o) >= $signed($past(opb_i))));
endmodule

bind cl_alu cl_alu_chk #(.WIDTH(WIDTH)) u_cl_alu_chk (.*);

// File: tb/test_cl_alu.sv
module test_cl_alu;
    localparam int W = 32;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = 4'd0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] opb_i = '0;
    logic [W-1:0] opc_i = '0;
    logic [W-1:0] res_o;
    logic [W-1:0] cw_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cl_alu #(.WIDTH(W)) i_cl_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i),
        .res_o(res_o), .cw_o(cw_o)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] c,
                       input logic [W-1:0] er, input logic [W-1:0] ec);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; opc_i = c;
        @(negedge clk);
        check({tag, " res"}, res_o, er);
        check({tag, " cw"}, cw_o, ec);
    endtask

    task automatic t_reset;
        // R1: inputs request a carry, reset must still hold zero
        op_i = 4'd2; opa_i = '1; opb_i = 32'd1; opc_i = 32'd1;
        repeat (3) @(negedge clk);
        check("R1 res", res_o, '0);
        check("R1 cw", cw_o, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        // R2: value appears after one edge and holds while inputs change late
        @(negedge clk);
        op_i = 4'd0; opa_i = 32'd10; opb_i = 32'd20; opc_i = '0;
        @(posedge clk);
        #1;
        opa_i = 32'd99;
        #1;
        check("R2 after edge", res_o, 32'd30);
        @(negedge clk);
        check("R2 held", res_o, 32'd30);
    endtask

    task automatic t_arith;
        run("R3 add", 4'd0, 32'h12345678, 32'h11111111, '0, 32'h23456789, '0);
        run("R3 sub neg", 4'd1, 32'd5, 32'd7, '0, 32'hFFFFFFFE, '0);
        run("R3 sub min", 4'd1, 32'h80000000, 32'd1, '0, 32'h7FFFFFFF, '0);
        run("R5 add wrap", 4'd0, 32'hFFFFFFFF, 32'd1, '0, 32'h0, '0);
        run("R5 sub borrow", 4'd1, 32'd0, 32'd1, '0, 32'hFFFFFFFF, '0);
    endtask

    task automatic t_adc;
        run("R4 all ones", 4'd2, 32'hFFFFFFFF, 32'd0, 32'd1, 32'h0, 32'd1);
        run("R4 no carry", 4'd2, 32'h7FFFFFFF, 32'd1, 32'd0, 32'h80000000, 32'd0);
        run("R4 upper c ignored", 4'd2, 32'd1, 32'd2, 32'hFFFFFFFE, 32'd3, 32'd0);
        run("R4 sign carry", 4'd2, 32'h80000000, 32'h80000000, 32'h80000001, 32'd1, 32'd1);
    endtask

    task automatic t_bool;
        run("R6 and",  4'd3, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'hF000F000, '0);
        run("R6 or",   4'd4, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'hFFF0FFF0, '0);
        run("R6 xor",  4'd5, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'h0FF00FF0, '0);
        run("R6 andn", 4'd6, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'h00F000F0, '0);
        run("R6 orn",  4'd7, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'hF0FFF0FF, '0);
        run("R6 xnor", 4'd8, 32'hF0F0F0F0, 32'hFF00FF00, '0, 32'hF00FF00F, '0);
    endtask

    task automatic t_unsigned;
        run("R7 umin", 4'd9,  32'hFFFFFFFF, 32'd1, '0, 32'd1, '0);
        run("R7 umax", 4'd10, 32'hFFFFFFFF, 32'd1, '0, 32'hFFFFFFFF, '0);
        run("R7 umin eq", 4'd9, 32'd3, 32'd3, '0, 32'd3, '0);
    endtask

    task automatic t_signed;
        run("R8 smin", 4'd11, 32'hFFFFFFFF, 32'd1, '0, 32'hFFFFFFFF, '0);
        run("R8 smax", 4'd12, 32'hFFFFFFFF, 32'd1, '0, 32'd1, '0);
        run("R8 smin extremes", 4'd11, 32'h80000000, 32'h7FFFFFFF, '0, 32'h80000000, '0);
        run("R8 smax negatives", 4'd12, 32'hFFFFFFFB, 32'hFFFFFFFD, '0, 32'hFFFFFFFD, '0);
    endtask

    task automatic t_spare;
        // R9: spare codes give zero; preceding carry must also clear (R5)
        run("R9 pre adc", 4'd2, 32'hFFFFFFFF, 32'd1, '0, 32'h0, 32'd1);
        run("R9 code13", 4'd13, 32'h1234, 32'h5678, 32'd1, '0, '0);
        run("R9 code14", 4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, '0, '0, '0);
        run("R9 code15", 4'd15, 32'hA5A5A5A5, 32'h5A5A5A5A, '0, '0, '0);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_arith();
        t_adc();
        t_bool();
        t_unsigned();
        t_signed();
        t_spare();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule